// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Status Flags

This block is the arithmetic and logic stage of a small register-based microcontroller core. It is purely combinational and settles within one clock cycle. Two W-bit operands arrive from the register file, or one register and one immediate; the mux that picks between them lives in the datapath outside this block. The block also takes an operation code and the current carry flag. It returns the result, a result write enable, the new values of six status flags, and one update enable per flag. The core's status register loads only the flags whose enable is high and keeps the others.

The supported operations are:
- add and subtract, each with or without carry;
- compare, with or without carry;
- AND, OR and exclusive OR;
- one's complement and two's-complement negate;
- increment and decrement;
- logical shifts left and right, and arithmetic shift right;
- rotates left and right through carry;
- nibble exchange.

Each operation has its own rule for which flags it touches. Subtract-with-carry and compare-with-carry can only clear the zero flag, so that a multi-byte compare sees the zero status of the whole chain.

Top module: `alu8_core`

## Requirements
- R1: Operation codes on `op_i` are ADD=0, ADC=1, SUB=2, SBC=3, CP=4, CPC=5, AND=6, OR=7, XOR=8, COM=9, NEG=10, INC=11, DEC=12, LSL=13, LSR=14, ROL=15, ROR=16, ASR=17, SWAP=18. ADD gives a+b, ADC gives a+b+c_i, SUB gives a-b and SBC gives a-b-c_i, all modulo 2^W, with `res_we_o` high.
- R2: The flag positions in `flags_o` and `flags_we_o` are bit0 C, bit1 Z, bit2 N, bit3 V, bit4 S and bit5 H. For ADD, ADC, SUB and SBC all six flags are enabled. C is the carry or borrow out of the MSB, H is the carry or borrow out of bit W/2-1, and V is two's-complement overflow.
- R3: Whenever N is enabled it equals the result MSB, Z is 1 exactly for a zero result (except under R4), and S equals N xor V.
- R4: For SBC and CPC, Z is enabled only when the result is nonzero, and its value is then 0.
- R5: CP and CPC give the same result and flags as SUB and SBC, but with `res_we_o` low.
- R6: AND, OR and XOR give the bitwise result and enable Z, N, V and S, with V=0. COM gives ~a with V=0 and C=1 and C enabled. None of these four enables H.
- R7: NEG gives 0-a with all flags enabled. C=1 when the result is nonzero, H=1 when a[W/2-1:0] is nonzero, and V=1 only when the result is 100..0.
- R8: INC and DEC give a+1 and a-1 and enable only Z, N, V and S. V=1 only for 011..1 to 100..0 (INC) and 100..0 to 011..1 (DEC).
- R9: LSL shifts in 0 and ROL shifts in c_i at bit 0. LSR shifts in 0, ROR shifts in c_i and ASR keeps the MSB at the top bit. C takes the bit shifted out and V=N xor C. LSL and ROL also enable H, set to a[W/2-1]. The right shifts do not enable H.
- R10: SWAP exchanges the upper and lower halves of a. All flag enables are 0 and `res_we_o` is high.
- R11: Codes 19 to 31 give result 0 with `res_we_o` and all flag enables low. Any flag whose enable is low reads 0 on `flags_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand (destination register) |
| b_i | input | W | Second operand (register or immediate) |
| c_i | input | 1 | Current carry flag |
| op_i | input | 5 | Operation code (R1) |
| res_o | output | W | Result |
| res_we_o | output | 1 | Result write-back enable |
| flags_o | output | 6 | New flag values {H,S,V,N,Z,C} |
| flags_we_o | output | 6 | Per-flag update enables, same layout |

## Verification
The hardest conditions to reach from the ports are the ones that need one exact operand pair. The V corners of INC, DEC and NEG need 0x7F, 0x80 and 0x80. A nibble borrow in SBC that appears only because of the incoming carry needs matching low nibbles with c_i set. The zero-only-cleared rule needs an SBC or CPC whose difference is exactly zero. Directed vectors set each of these up explicitly. A long pseudo-random run over all 32 codes then cross-checks every output against a behavioural integer model on every clock, including the undefined codes.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
  localparam int NFLAGS = 6;
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CP  = 5'd4,  OP_CPC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
    OP_XOR = 5'd8,  OP_COM = 5'd9,  OP_NEG = 5'd10, OP_INC = 5'd11,
    OP_DEC = 5'd12, OP_LSL = 5'd13, OP_LSR = 5'd14, OP_ROL = 5'd15,
    OP_ROR = 5'd16, OP_ASR = 5'd17, OP_SWAP = 5'd18
  } alu_op_e;

  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR, LG_NOT} logic_sel_e;

  typedef enum logic [2:0] {
    SH_LSL, SH_ROL, SH_LSR, SH_ROR, SH_ASR, SH_SWAP
  } shift_sel_e;

  typedef enum logic [1:0] {UNIT_NONE, UNIT_ARITH, UNIT_LOGIC, UNIT_SHIFT} unit_e;
endpackage

// File: rtl/alu8_addsub.sv
`timescale 1ns/1ps
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         h_o,
  output logic         v_o
);
  localparam int HW = W / 2;

  logic [W-1:0] y_eff;
  logic         ci;
  logic [W:0]   full;
  logic [HW:0]  half;

  // subtract as x + ~y + ~borrow; carry-outs inverted to become borrows
  assign y_eff = sub_i ? ~y_i : y_i;
  assign ci    = sub_i ^ cin_i;
  assign full  = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, ci};
  assign half  = {1'b0, x_i[HW-1:0]} + {1'b0, y_eff[HW-1:0]} + {{HW{1'b0}}, ci};

  assign sum_o = full[W-1:0];
  assign c_o   = full[W] ^ sub_i;
  assign h_o   = half[HW] ^ sub_i;
  assign v_o   = (x_i[W-1] == y_eff[W-1]) && (full[W-1] != x_i[W-1]);
endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_sel_e   sel_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = ~a_i;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
`timescale 1ns/1ps
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  input  shift_sel_e   sel_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  localparam int HW = W / 2;

  logic [W-1:0] swapped;

  for (genvar i = 0; i < W; i++) begin : g_swap
    assign swapped[i] = a_i[(i + HW) % W];
  end

  always_comb begin
    res_o = a_i;
    c_o   = 1'b0;
    case (sel_i)
      SH_LSL:  begin res_o = {a_i[W-2:0], 1'b0};     c_o = a_i[W-1]; end
      SH_ROL:  begin res_o = {a_i[W-2:0], cin_i};    c_o = a_i[W-1]; end
      SH_LSR:  begin res_o = {1'b0, a_i[W-1:1]};     c_o = a_i[0];   end
      SH_ROR:  begin res_o = {cin_i, a_i[W-1:1]};    c_o = a_i[0];   end
      SH_ASR:  begin res_o = {a_i[W-1], a_i[W-1:1]}; c_o = a_i[0];   end
      SH_SWAP: res_o = swapped;
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic              c_i,
  input  logic [4:0]        op_i,
  output logic [W-1:0]      res_o,
  output logic              res_we_o,
  output logic [NFLAGS-1:0] flags_o,
  output logic [NFLAGS-1:0] flags_we_o
);
  localparam int HW = W / 2;
  localparam logic [NFLAGS-1:0] WE_ALL  = '1;
  localparam logic [NFLAGS-1:0] WE_ZNVS = NFLAGS'((1 << FL_Z) | (1 << FL_N) | (1 << FL_V) | (1 << FL_S));
  localparam logic [NFLAGS-1:0] WE_ZNVSC = WE_ZNVS | NFLAGS'(1 << FL_C);

  alu_op_e    op;
  unit_e      unit;
  logic [W-1:0] x, y;
  logic       cin, sub;
  logic_sel_e lsel;
  shift_sel_e ssel;
  logic       chain_z;
  logic       write_res;
  logic       force_c;
  logic       h_from_a;
  logic [NFLAGS-1:0] we_base;

  logic [W-1:0] as_sum, lg_res, sh_res;
  logic         as_c, as_h, as_v, sh_c;

  assign op = alu_op_e'(op_i);

  // decode
  always_comb begin
    unit      = UNIT_NONE;
    x         = a_i;
    y         = b_i;
    cin       = 1'b0;
    sub       = 1'b0;
    lsel      = LG_AND;
    ssel      = SH_LSL;
    chain_z   = 1'b0;
    write_res = 1'b1;
    force_c   = 1'b0;
    h_from_a  = 1'b0;
    we_base   = '0;
    case (op)
      OP_ADD:  begin unit = UNIT_ARITH; we_base = WE_ALL; end
      OP_ADC:  begin unit = UNIT_ARITH; cin = c_i; we_base = WE_ALL; end
      OP_SUB:  begin unit = UNIT_ARITH; sub = 1'b1; we_base = WE_ALL; end
      OP_SBC:  begin unit = UNIT_ARITH; sub = 1'b1; cin = c_i; chain_z = 1'b1; we_base = WE_ALL; end
      OP_CP:   begin unit = UNIT_ARITH; sub = 1'b1; write_res = 1'b0; we_base = WE_ALL; end
      OP_CPC:  begin unit = UNIT_ARITH; sub = 1'b1; cin = c_i; chain_z = 1'b1;
                     write_res = 1'b0; we_base = WE_ALL; end
      OP_NEG:  begin unit = UNIT_ARITH; sub = 1'b1; x = '0; y = a_i; we_base = WE_ALL; end
      OP_INC:  begin unit = UNIT_ARITH; y = W'(1); we_base = WE_ZNVS; end
      OP_DEC:  begin unit = UNIT_ARITH; sub = 1'b1; y = W'(1); we_base = WE_ZNVS; end
      OP_AND:  begin unit = UNIT_LOGIC; lsel = LG_AND; we_base = WE_ZNVS; end
      OP_OR:   begin unit = UNIT_LOGIC; lsel = LG_OR;  we_base = WE_ZNVS; end
      OP_XOR:  begin unit = UNIT_LOGIC; lsel = LG_XOR; we_base = WE_ZNVS; end
      OP_COM:  begin unit = UNIT_LOGIC; lsel = LG_NOT; force_c = 1'b1; we_base = WE_ZNVSC; end
      OP_LSL:  begin unit = UNIT_SHIFT; ssel = SH_LSL; h_from_a = 1'b1; we_base = WE_ALL; end
      OP_ROL:  begin unit = UNIT_SHIFT; ssel = SH_ROL; h_from_a = 1'b1; we_base = WE_ALL; end
      OP_LSR:  begin unit = UNIT_SHIFT; ssel = SH_LSR; we_base = WE_ZNVSC; end
      OP_ROR:  begin unit = UNIT_SHIFT; ssel = SH_ROR; we_base = WE_ZNVSC; end
      OP_ASR:  begin unit = UNIT_SHIFT; ssel = SH_ASR; we_base = WE_ZNVSC; end
      OP_SWAP: begin unit = UNIT_SHIFT; ssel = SH_SWAP; end
      default: write_res = 1'b0;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .x_i   (x),
    .y_i   (y),
    .cin_i (cin),
    .sub_i (sub),
    .sum_o (as_sum),
    .c_o   (as_c),
    .h_o   (as_h),
    .v_o   (as_v)
  );

  alu8_logic #(.W(W)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (lsel),
    .res_o (lg_res)
  );

  alu8_shift #(.W(W)) u_shift (
    .a_i   (a_i),
    .cin_i (c_i),
    .sel_i (ssel),
    .res_o (sh_res),
    .c_o   (sh_c)
  );

  // result select and flag assembly
  logic [W-1:0]      res;
  logic [NFLAGS-1:0] fl, we;
  logic              f_c, f_h, f_v, f_n, f_z;

  always_comb begin
    res = '0;
    f_c = 1'b0;
    f_h = 1'b0;
    f_v = 1'b0;
    case (unit)
      UNIT_ARITH: begin res = as_sum; f_c = as_c; f_h = as_h; f_v = as_v; end
      UNIT_LOGIC: begin res = lg_res; f_c = force_c; end
      UNIT_SHIFT: begin res = sh_res; f_c = sh_c; f_h = h_from_a & a_i[HW-1];
                        f_v = sh_res[W-1] ^ sh_c; end
      default: ;
    endcase
    f_n = res[W-1];
    f_z = (res == '0) && !chain_z;
    we  = we_base;
    if (chain_z && (res == '0)) we[FL_Z] = 1'b0;
    fl        = '0;
    fl[FL_C]  = f_c;
    fl[FL_Z]  = f_z;
    fl[FL_N]  = f_n;
    fl[FL_V]  = f_v;
    fl[FL_S]  = f_n ^ f_v;
    fl[FL_H]  = f_h;
  end

  assign res_o      = res;
  assign res_we_o   = write_res;
  assign flags_we_o = we;
  assign flags_o    = fl & we;

  // checks
  always_comb begin
    if (op_i == 5'd4 || op_i == 5'd5)
      AST_CMP_NO_WRITE: assert (!res_we_o); // R5
    if (op_i == 5'd3 || op_i == 5'd5)
      if (flags_we_o[FL_Z])
        AST_CHAIN_Z_CLEAR_ONLY: assert (!flags_o[FL_Z] && res_o != '0); // R4
    if (op_i == 5'd9)
      AST_COM_SETS_CARRY: assert (flags_we_o[FL_C] && flags_o[FL_C] && res_o == ~a_i); // R6
    if (op_i >= 5'd6 && op_i <= 5'd8)
      AST_LOGIC_CLEARS_V: assert (flags_we_o[FL_V] && !flags_o[FL_V] && !flags_we_o[FL_H]); // R6
    if (op_i == 5'd11 || op_i == 5'd12)
      AST_INCDEC_KEEP_CH: assert (!flags_we_o[FL_C] && !flags_we_o[FL_H]); // R8
    if (op_i == 5'd18)
      AST_SWAP_NO_FLAGS: assert (flags_we_o == '0 && res_o == {a_i[HW-1:0], a_i[W-1:HW]}); // R10
    if (op_i > 5'd18)
      AST_UNDEF_QUIET: assert (!res_we_o && flags_we_o == '0 && res_o == '0); // R11
    if (flags_we_o[FL_N])
      AST_N_IS_MSB: assert (flags_o[FL_N] == res_o[W-1]); // R3
  end
endmodule

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic [7:0] a, b;
  logic       c;
  logic [4:0] op;
  logic [7:0] res_o;
  logic       res_we_o;
  logic [5:0] flags_o, flags_we_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  bit [31:0] rng = 32'h1234_5677;

  alu8_core #(.W(W)) u0 (
    .a_i        (a),
    .b_i        (b),
    .c_i        (c),
    .op_i       (op),
    .res_o      (res_o),
    .res_we_o   (res_we_o),
    .flags_o    (flags_o),
    .flags_we_o (flags_we_o)
  );

  function automatic string tag(int o);
    case (o)
      0, 1, 2: return "R1 R2 R3";
      3:       return "R4 R1";
      4:       return "R5";
      5:       return "R5 R4";
      6, 7, 8, 9: return "R6";
      10:      return "R7";
      11, 12:  return "R8";
      13, 14, 15, 16, 17: return "R9";
      18:      return "R10";
      default: return "R11";
    endcase
  endfunction

  // behavioural reference: flags as integer bit set C=1 Z=2 N=4 V=8 S=16 H=32
  task automatic model(input int o, input int av, input int bv, input int cv,
                       output int r, output int rwe, output int fl, output int fwe);
    int cc, hh, vv, ci, nn, zz;
    cc = 0; hh = 0; vv = 0; r = 0; rwe = 1; fwe = 0;
    case (o)
      0, 1: begin
        ci = (o == 1) ? cv : 0;
        r  = (av + bv + ci) & 255;
        cc = (av + bv + ci) > 255 ? 1 : 0;
        hh = ((av & 15) + (bv & 15) + ci) > 15 ? 1 : 0;
        vv = (((av ^ r) & (bv ^ r) & 128) != 0) ? 1 : 0;
        fwe = 63;
      end
      2, 3, 4, 5: begin
        ci = (o == 3 || o == 5) ? cv : 0;
        r  = (av - bv - ci) & 255;
        cc = (av < bv + ci) ? 1 : 0;
        hh = ((av & 15) < (bv & 15) + ci) ? 1 : 0;
        vv = (((av ^ bv) & (av ^ r) & 128) != 0) ? 1 : 0;
        fwe = 63;
        rwe = (o < 4) ? 1 : 0;
      end
      6:  begin r = av & bv; fwe = 30; end
      7:  begin r = av | bv; fwe = 30; end
      8:  begin r = av ^ bv; fwe = 30; end
      9:  begin r = 255 - av; cc = 1; fwe = 31; end
      10: begin r = (256 - av) & 255; cc = (r != 0) ? 1 : 0;
                hh = ((av & 15) != 0) ? 1 : 0; vv = (r == 128) ? 1 : 0; fwe = 63; end
      11: begin r = (av + 1) & 255; vv = (av == 127) ? 1 : 0; fwe = 30; end
      12: begin r = (av + 255) & 255; vv = (av == 128) ? 1 : 0; fwe = 30; end
      13: begin r = (av * 2) & 255; cc = av / 128; hh = (av / 8) % 2; fwe = 63; end
      15: begin r = (av * 2 + cv) & 255; cc = av / 128; hh = (av / 8) % 2; fwe = 63; end
      14: begin r = av / 2; cc = av % 2; fwe = 31; end
      16: begin r = av / 2 + cv * 128; cc = av % 2; fwe = 31; end
      17: begin r = av / 2 + (av & 128); cc = av % 2; fwe = 31; end
      18: begin r = (av % 16) * 16 + av / 16; end
      default: begin r = 0; rwe = 0; end
    endcase
    if (o >= 13 && o <= 17) vv = (r / 128) ^ cc;
    nn = r / 128;
    zz = (r == 0) ? 1 : 0;
    fl = cc + 2 * zz + 4 * nn + 8 * vv + 16 * (nn ^ vv) + 32 * hh;
    if (o == 3 || o == 5) begin
      fl = fl & ~2;
      if (r == 0) fwe = fwe & ~2;
    end
    fl = fl & fwe;
  endtask

  task automatic apply(input int o, input int av, input int bv, input int cv);
    int er, erwe, efl, efwe;
    model(o, av, bv, cv, er, erwe, efl, efwe);
    @(posedge clk);
    #1;
    op = 5'(o); a = 8'(av); b = 8'(bv); c = cv[0];
    @(negedge clk);
    n_tests++;
    if (int'(res_o) != er || int'(res_we_o) != erwe ||
        int'(flags_o) != efl || int'(flags_we_o) != efwe) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%02h b=%02h c=%0d: got res=%02h we=%0d fl=%02h fwe=%02h, expected res=%02h we=%0d fl=%02h fwe=%02h",
               tag(o), o, av, bv, cv, res_o, res_we_o, flags_o, flags_we_o, er, erwe, efl, efwe);
    end
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a = '0; b = '0; c = 1'b0; op = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_tests++; // idle state: ADD of zeros, R1 R3
    if (res_o != 8'h00 || flags_o != 6'h02 || flags_we_o != 6'h3f || !res_we_o) begin
      n_fail++;
      $display("FAIL R1 R3 idle: got res=%02h fl=%02h fwe=%02h, expected res=00 fl=02 fwe=3f",
               res_o, flags_o, flags_we_o);
    end
    rst_n = 1'b1;

    // R1 R2 R3 add and subtract corners
    apply(0, 'h7f, 'h01, 0);
    apply(0, 'hff, 'h01, 0);
    apply(1, 'h0f, 'h00, 1);
    apply(1, 'hff, 'hff, 1);
    apply(2, 'h00, 'h01, 0);
    apply(2, 'h80, 'h01, 0);
    apply(2, 'h10, 'h01, 1);
    // R4 chain zero
    apply(3, 'h00, 'h00, 0);
    apply(3, 'h01, 'h00, 1);
    apply(3, 'h05, 'h03, 1);
    apply(3, 'h10, 'h0f, 1);
    // R5 compares
    apply(4, 'h42, 'h42, 0);
    apply(4, 'h01, 'h02, 1);
    apply(5, 'h00, 'h00, 1);
    apply(5, 'h33, 'h33, 0);
    // R6 logic
    apply(6, 'hf0, 'h0f, 1);
    apply(7, 'h80, 'h01, 0);
    apply(8, 'hff, 'h7f, 1);
    apply(9, 'h00, 'h00, 0);
    apply(9, 'hff, 'h00, 0);
    // R7 negate
    apply(10, 'h00, 0, 0);
    apply(10, 'h80, 0, 0);
    apply(10, 'h01, 0, 1);
    apply(10, 'h10, 0, 0);
    // R8 inc / dec
    apply(11, 'h7f, 0, 1);
    apply(11, 'hff, 0, 0);
    apply(12, 'h80, 0, 0);
    apply(12, 'h00, 0, 1);
    apply(12, 'h01, 0, 0);
    // R9 shifts and rotates
    apply(13, 'h88, 0, 1);
    apply(15, 'h80, 0, 1);
    apply(15, 'h08, 0, 0);
    apply(14, 'h01, 0, 0);
    apply(16, 'h01, 0, 1);
    apply(16, 'h00, 0, 1);
    apply(17, 'h81, 0, 0);
    apply(17, 'h40, 0, 1);
    // R10 swap
    apply(18, 'ha5, 'hff, 1);
    apply(18, 'h0f, 0, 0);
    // R11 undefined codes
    apply(19, 'h12, 'h34, 1);
    apply(31, 'hff, 'hff, 1);

    for (int i = 0; i < 4000; i++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      apply(int'(rng[4:0]), int'(rng[12:5]), int'(rng[20:13]), int'(rng[21]));
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule